// File: doc/BRIEF.md
# I/O Pin Function and Pad Configuration Bank

This block holds the per-pin configuration for a set of general-purpose I/O pins that are grouped into banks of equal size. Software reaches it through a plain word-addressed register port with a per-bit write mask. For every pin the block stores a 3-bit function code, a 2-bit pull code, a 2-bit drive code and one output data bit. From these it drives the pad controls: output enable, output value, pull-up and pull-down enables, drive code, the raw function code for peripheral routing, and a flag that routes the pin to the external-interrupt logic.

Pin inputs pass through a two-stage synchronizer. A read of a bank's data word returns the live, synchronized level only for pins whose function code is GPIO input. Every other pin returns its stored output bit, and that includes pins set to the interrupt function. Software that needs the level of an interrupt pin therefore switches the pin to input, reads the data word, and then restores the interrupt code. Every field update is a masked write, so software can change one pin's field without disturbing its neighbours.

Top module: `pinbank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every pin has function code 0 (GPIO input), pull code 0, drive code 0 and output bit 0. As a result pad_oe, pad_out, pad_pu, pad_pd, pad_drv and pad_irq_sel are all zero, and every configuration word reads 0.
- R2: Function codes are 0 = GPIO input, 1 = GPIO output, 2..5 = peripheral functions, 6 = external interrupt and 7 = disabled. pad_oe of a pin is 1 only for code 1. pad_irq_sel is 1 only for code 6. pad_func carries the 3-bit code of pin p at bits [3p+2:3p].
- R3: The word address is bank*16 + offset. Offsets 0..3 are function words: pin i uses word i/8, bits [(i%8)*4+2:(i%8)*4], and the fourth bit of each nibble reads 0. Offset 4 is the data word, with bit i for pin i. Offsets 5..6 are drive words: word 5 + i/16, bits [(i%16)*2+1:(i%16)*2]. Offsets 7..8 are pull words, laid out the same way from offset 7.
- R4: A write changes only the bits whose reg_wmask bit is 1. Neighbouring fields in the same word keep their values, and a write with an all-zero mask changes nothing.
- R5: Pull code 1 asserts pad_pu and code 2 asserts pad_pd. Codes 0 and 3 assert neither. The stored code, including 3, reads back unchanged. pad_pu and pad_pd are never both 1 for one pin.
- R6: The drive code (0..3, meaning 10 to 40 mA in steps of 10 mA) of pin p appears on pad_drv bits [2p+1:2p] and reads back unchanged.
- R7: A write to a data word sets the stored output bit of each masked pin, and pad_out shows the stored bit from the next clock edge on.
- R8: A data-word read returns, for a pin with function code 0, the level of pad_in after two synchronizer flops: a change applied before edge k is visible after edge k+1. For any other function code the read returns the stored output bit. reg_rdata is combinational from reg_addr.
- R9: While a pin has code 6 its data bit reads the stored bit. After the pin is switched to code 0 it reads the synchronized level, and after code 6 is restored it reads the stored bit again with pad_irq_sel set.
- R10: Reads from an unmapped offset (9..15) or from a bank number of NUM_BANKS or above return 0, and writes to them change no pin.
- R11: The global pin number is bank*32 + index, and every per-pin port is indexed by that number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Word address: bank*16 + offset |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write enable |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pad_in | input | NUM_BANKS*32 | Asynchronous pin input levels |
| pad_oe | output | NUM_BANKS*32 | Output enable per pin |
| pad_out | output | NUM_BANKS*32 | Output value per pin |
| pad_pu | output | NUM_BANKS*32 | Pull-up enable per pin |
| pad_pd | output | NUM_BANKS*32 | Pull-down enable per pin |
| pad_drv | output | NUM_BANKS*64 | 2-bit drive code per pin |
| pad_func | output | NUM_BANKS*96 | 3-bit function code per pin |
| pad_irq_sel | output | NUM_BANKS*32 | Pin routed to interrupt logic |

## Verification
The assertions check on every cycle that no pin has both pull enables set, that no pin is both output-enabled and routed to interrupt, that a write with an empty mask leaves all pad controls unchanged, that a bank-0 data write updates pad_out exactly under its mask, and that unmapped offsets read zero. The bench scenarios cover the rest. These are the field layout and nibble packing of each word, the two-cycle synchronizer latency, the choice between live level and stored bit on a data read, the interrupt remux sequence, and the numbering of pins in the second bank, none of which a single-cycle property can show.

// File: rtl/pinbank_pkg.sv
// Shared codes and layout constants for the pin configuration bank.
// Assumes a 32-bit register word and 16-word address space per bank.
package pinbank_pkg;
    localparam int WORD_W        = 32;
    localparam int OFF_W         = 4;   // word offset bits inside a bank
    localparam int FUNC_W        = 3;
    localparam int FUNC_SLOT_W   = 4;   // nibble per pin in function words
    localparam int CODE2_W       = 2;   // pull and drive field width
    localparam int FUNCS_PER_WORD = WORD_W / FUNC_SLOT_W;
    localparam int CODE2_PER_WORD = WORD_W / CODE2_W;

    typedef enum logic [FUNC_W-1:0] {
        FN_GPIO_IN  = 3'd0,
        FN_GPIO_OUT = 3'd1,
        FN_PERIPH0  = 3'd2,
        FN_PERIPH1  = 3'd3,
        FN_PERIPH2  = 3'd4,
        FN_PERIPH3  = 3'd5,
        FN_EXT_IRQ  = 3'd6,
        FN_OFF      = 3'd7
    } pin_func_e;

    localparam logic [CODE2_W-1:0] PULL_UP_CODE   = 2'd1;
    localparam logic [CODE2_W-1:0] PULL_DOWN_CODE = 2'd2;
endpackage

// File: rtl/pinbank_sync.sv
// Two-flop synchronizer for the asynchronous pin inputs.
// Assumes each bit is an independent level; no bus coherency is needed.
module pinbank_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two-stage capture of pin levels, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/pinbank_regs.sv
// Per-pin configuration storage with masked writes and a combinational
// read path. Assumes PINS_PER_BANK is 16 or 32 so one data word covers
// a bank and the bank's words fit in 16 offsets.
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NUM_BANKS     = 2,
    parameter int PINS_PER_BANK = 32,
    parameter int ADDR_W        = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [WORD_W-1:0]              wmask,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_level,
    output logic [WORD_W-1:0]              rdata,
    output logic [NUM_BANKS*PINS_PER_BANK*FUNC_W-1:0]  func_flat,
    output logic [NUM_BANKS*PINS_PER_BANK*CODE2_W-1:0] pull_flat,
    output logic [NUM_BANKS*PINS_PER_BANK*CODE2_W-1:0] drv_flat,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0]         dout_flat
);
    localparam int NPINS      = NUM_BANKS * PINS_PER_BANK;
    localparam int BANK_W     = ADDR_W - OFF_W;
    localparam int FUNC_WORDS = PINS_PER_BANK / FUNCS_PER_WORD;
    localparam int C2_WORDS   = PINS_PER_BANK / CODE2_PER_WORD;
    localparam int DATA_OFF   = FUNC_WORDS;
    localparam int DRV_BASE   = DATA_OFF + 1;
    localparam int PULL_BASE  = DRV_BASE + C2_WORDS;
    localparam int LAST_OFF   = PULL_BASE + C2_WORDS - 1;

    logic [BANK_W-1:0] bank_sel;
    logic [OFF_W-1:0]  off_sel;

    assign bank_sel = addr[ADDR_W-1:OFF_W];
    assign off_sel  = addr[OFF_W-1:0];

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int BANK   = p / PINS_PER_BANK;
        localparam int IDX    = p % PINS_PER_BANK;
        localparam int F_OFF  = IDX / FUNCS_PER_WORD;
        localparam int F_LSB  = (IDX % FUNCS_PER_WORD) * FUNC_SLOT_W;
        localparam int C_LSB  = (IDX % CODE2_PER_WORD) * CODE2_W;
        localparam int D_OFF  = DRV_BASE + IDX / CODE2_PER_WORD;
        localparam int P_OFF  = PULL_BASE + IDX / CODE2_PER_WORD;

        logic [FUNC_W-1:0]  func_q;
        logic [CODE2_W-1:0] pull_q;
        logic [CODE2_W-1:0] drv_q;
        logic               dout_q;
        logic               hit;

        assign hit = we && (int'(bank_sel) == BANK);

        // Masked update of this pin's fields from the addressed word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                func_q <= FN_GPIO_IN;
                pull_q <= '0;
                drv_q  <= '0;
                dout_q <= 1'b0;
            end else if (hit) begin
                if (int'(off_sel) == F_OFF)
                    func_q <= (func_q & ~wmask[F_LSB +: FUNC_W])
                            | (wdata[F_LSB +: FUNC_W] & wmask[F_LSB +: FUNC_W]);
                if (int'(off_sel) == DATA_OFF && wmask[IDX])
                    dout_q <= wdata[IDX];
                if (int'(off_sel) == D_OFF)
                    drv_q <= (drv_q & ~wmask[C_LSB +: CODE2_W])
                           | (wdata[C_LSB +: CODE2_W] & wmask[C_LSB +: CODE2_W]);
                if (int'(off_sel) == P_OFF)
                    pull_q <= (pull_q & ~wmask[C_LSB +: CODE2_W])
                            | (wdata[C_LSB +: CODE2_W] & wmask[C_LSB +: CODE2_W]);
            end
        end

        assign func_flat[p*FUNC_W +: FUNC_W]  = func_q;
        assign pull_flat[p*CODE2_W +: CODE2_W] = pull_q;
        assign drv_flat[p*CODE2_W +: CODE2_W]  = drv_q;
        assign dout_flat[p]                    = dout_q;
    end

    // Assemble the addressed word from the fields of the selected bank.
    always_comb begin
        rdata = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (int'(bank_sel) == p / PINS_PER_BANK) begin
                if (int'(off_sel) == (p % PINS_PER_BANK) / FUNCS_PER_WORD)
                    rdata[((p % PINS_PER_BANK) % FUNCS_PER_WORD) * FUNC_SLOT_W +: FUNC_W]
                        = func_flat[p*FUNC_W +: FUNC_W];
                if (int'(off_sel) == DATA_OFF)
                    rdata[p % PINS_PER_BANK] =
                        (func_flat[p*FUNC_W +: FUNC_W] == FN_GPIO_IN) ? pin_level[p]
                                                                     : dout_flat[p];
                if (int'(off_sel) == DRV_BASE + (p % PINS_PER_BANK) / CODE2_PER_WORD)
                    rdata[((p % PINS_PER_BANK) % CODE2_PER_WORD) * CODE2_W +: CODE2_W]
                        = drv_flat[p*CODE2_W +: CODE2_W];
                if (int'(off_sel) == PULL_BASE + (p % PINS_PER_BANK) / CODE2_PER_WORD)
                    rdata[((p % PINS_PER_BANK) % CODE2_PER_WORD) * CODE2_W +: CODE2_W]
                        = pull_flat[p*CODE2_W +: CODE2_W];
            end
        end
    end

    // R10: offsets past the last pull word never return data.
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(off_sel) > LAST_OFF) |-> (rdata == '0));
endmodule

// File: rtl/pinbank_pad_decode.sv
// Turns stored per-pin fields into pad control signals.
// Assumes codes from pinbank_pkg; purely combinational.
module pinbank_pad_decode
    import pinbank_pkg::*;
#(
    parameter int NPINS = 64
) (
    input  logic [NPINS*FUNC_W-1:0]  func_flat,
    input  logic [NPINS*CODE2_W-1:0] pull_flat,
    input  logic [NPINS*CODE2_W-1:0] drv_flat,
    input  logic [NPINS-1:0]         dout_flat,
    output logic [NPINS-1:0]         oe,
    output logic [NPINS-1:0]         out_val,
    output logic [NPINS-1:0]         pull_up,
    output logic [NPINS-1:0]         pull_down,
    output logic [NPINS*CODE2_W-1:0] drive,
    output logic [NPINS*FUNC_W-1:0]  func_sel,
    output logic [NPINS-1:0]         irq_route
);
    for (genvar p = 0; p < NPINS; p++) begin : g_dec
        logic [FUNC_W-1:0]  fcode;
        logic [CODE2_W-1:0] pcode;

        assign fcode = func_flat[p*FUNC_W +: FUNC_W];
        assign pcode = pull_flat[p*CODE2_W +: CODE2_W];

        // Pad enables derived from the function and pull codes.
        always_comb begin
            oe[p]        = (fcode == FN_GPIO_OUT);
            irq_route[p] = (fcode == FN_EXT_IRQ);
            pull_up[p]   = (pcode == PULL_UP_CODE);
            pull_down[p] = (pcode == PULL_DOWN_CODE);
        end
    end

    assign out_val  = dout_flat;
    assign drive    = drv_flat;
    assign func_sel = func_flat;
endmodule

// File: rtl/pinbank_ctrl.sv
// Top of the pin function and pad configuration bank: register port,
// input synchronizer, field storage and pad decode.
// Assumes one register access per cycle and asynchronous pad inputs.
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NUM_BANKS     = 2,
    parameter int PINS_PER_BANK = 32,
    parameter int ADDR_W        = 6
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       reg_we,
    input  logic [ADDR_W-1:0]                          reg_addr,
    input  logic [31:0]                                reg_wdata,
    input  logic [31:0]                                reg_wmask,
    output logic [31:0]                                reg_rdata,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0]         pad_in,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0]         pad_oe,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0]         pad_out,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0]         pad_pu,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0]         pad_pd,
    output logic [NUM_BANKS*PINS_PER_BANK*2-1:0]       pad_drv,
    output logic [NUM_BANKS*PINS_PER_BANK*3-1:0]       pad_func,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0]         pad_irq_sel
);
    localparam int NPINS    = NUM_BANKS * PINS_PER_BANK;
    localparam int DATA_OFF = PINS_PER_BANK / FUNCS_PER_WORD;

    logic [NPINS-1:0]         level_sync;
    logic [NPINS*FUNC_W-1:0]  func_flat;
    logic [NPINS*CODE2_W-1:0] pull_flat;
    logic [NPINS*CODE2_W-1:0] drv_flat;
    logic [NPINS-1:0]         dout_flat;

    pinbank_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (level_sync)
    );

    pinbank_regs #(
        .NUM_BANKS     (NUM_BANKS),
        .PINS_PER_BANK (PINS_PER_BANK),
        .ADDR_W        (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .wmask     (reg_wmask),
        .pin_level (level_sync),
        .rdata     (reg_rdata),
        .func_flat (func_flat),
        .pull_flat (pull_flat),
        .drv_flat  (drv_flat),
        .dout_flat (dout_flat)
    );

    pinbank_pad_decode #(.NPINS(NPINS)) u_decode (
        .func_flat (func_flat),
        .pull_flat (pull_flat),
        .drv_flat  (drv_flat),
        .dout_flat (dout_flat),
        .oe        (pad_oe),
        .out_val   (pad_out),
        .pull_up   (pad_pu),
        .pull_down (pad_pd),
        .drive     (pad_drv),
        .func_sel  (pad_func),
        .irq_route (pad_irq_sel)
    );

    // R5: a pin is never pulled both ways.
    assert_pull_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    // R2: output drive and interrupt routing never coexist on a pin.
    assert_oe_vs_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_irq_sel) == '0);

    // R4: an empty write mask leaves every pad control untouched.
    assert_empty_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wmask == '0) |=>
            ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu) &&
             $stable(pad_pd) && $stable(pad_drv) && $stable(pad_func)));

    // R7: a bank-0 data write lands on pad_out under its mask one edge later.
    assert_data_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && int'(reg_addr) == DATA_OFF) |=>
            (pad_out[PINS_PER_BANK-1:0] ==
             (($past(pad_out[PINS_PER_BANK-1:0]) & ~$past(reg_wmask[PINS_PER_BANK-1:0])) |
              ($past(reg_wdata[PINS_PER_BANK-1:0]) & $past(reg_wmask[PINS_PER_BANK-1:0])))));
endmodule

// File: tb/test_pinbank_ctrl.sv
`timescale 1ns/1ps
module test_pinbank_ctrl;
    localparam int NB = 2;
    localparam int NP = 64;
    localparam int AW = 6;
    localparam time T_CLK = 20ns;

    typedef struct {
        int           kind;   // 0 rdata, 1 oe, 2 out, 3 pu, 4 pd, 5 irq, 6 drv, 7 func
        logic [127:0] exp;
        string        tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_we;
    logic [AW-1:0]     reg_addr;
    logic [31:0]       reg_wdata, reg_wmask, reg_rdata;
    logic [NP-1:0]     pad_in, pad_oe, pad_out, pad_pu, pad_pd, pad_irq_sel;
    logic [NP*2-1:0]   pad_drv;
    logic [NP*3-1:0]   pad_func;

    item_t q[$];
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(T_CLK/2) clk = ~clk;

    pinbank_ctrl #(.NUM_BANKS(NB), .PINS_PER_BANK(32), .ADDR_W(AW)) i_pinbank_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_drv(pad_drv), .pad_func(pad_func),
        .pad_irq_sel(pad_irq_sel)
    );

    function automatic logic [127:0] observe(int kind);
        case (kind)
            0: return {96'd0, reg_rdata};
            1: return {64'd0, pad_oe};
            2: return {64'd0, pad_out};
            3: return {64'd0, pad_pu};
            4: return {64'd0, pad_pd};
            5: return {64'd0, pad_irq_sel};
            6: return pad_drv;
            default: return pad_func[127:0];
        endcase
    endfunction

    // Monitor: pops expected items and compares away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [127:0] got;
                it = q.pop_front();
                got = observe(it.kind);
                vectors++;
                if (got !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d, input logic [31:0] m);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d; reg_wmask = m;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wmask = '0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = AW'(a);
        it.kind = 0; it.exp = {96'd0, e}; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic port(input int kind, input logic [127:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    initial begin
        #(T_CLK * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wmask = '0;
        pad_in = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(0, 32'h0, "R1 func word");
        rd(4, 32'h0, "R1 data word");
        rd(5, 32'h0, "R1 drive word");
        rd(7, 32'h0, "R1 pull word");
        port(1, '0, "R1 oe"); port(2, '0, "R1 out"); port(3, '0, "R1 pu");
        port(4, '0, "R1 pd"); port(5, '0, "R1 irq"); port(6, '0, "R1 drv");

        // R2 function codes and nibble packing (R3)
        wr(0, 32'h000F7361, 32'hFFFFFFFF);
        rd(0, 32'h00077361, "R2 R3 func readback");
        port(1, 128'h1, "R2 oe only code 1");
        port(5, 128'h2, "R2 irq only code 6");
        port(7, {113'd0, 3'd7, 3'd7, 3'd3, 3'd6, 3'd1}, "R2 func select");

        // R4 masked write touches only pin 1
        wr(0, 32'h00000002, 32'h000000F0);
        rd(0, 32'h00077301, "R4 neighbours kept");
        port(5, 128'h0, "R4 irq cleared");
        port(1, 128'h1, "R4 oe kept");

        // R11 bank 1 pin 63 as output
        wr(19, 32'h10000000, 32'hF0000000);
        port(1, (128'h1 << 63) | 128'h1, "R11 global pin 63");
        rd(19, 32'h10000000, "R11 bank1 func readback");

        // R6 drive code of pin 17
        wr(6, 32'h0000000C, 32'h0000000F);
        port(6, 128'h3 << 34, "R6 drive pin 17");
        rd(6, 32'h0000000C, "R6 drive readback");
        rd(5, 32'h0, "R6 other drive word");

        // R5 pull codes 1,2,3
        wr(7, 32'h00000039, 32'h000000FF);
        port(3, 128'h1, "R5 pull up");
        port(4, 128'h2, "R5 pull down");
        rd(7, 32'h00000039, "R5 pull readback");

        // R7 data writes under mask
        wr(4, 32'hFFFFFFFF, 32'h00000005);
        port(2, 128'h5, "R7 set bits");
        wr(4, 32'h0, 32'h00000001);
        port(2, 128'h4, "R7 clear bit");

        // R8 synchronizer latency and live/stored selection
        pad_in = '1;
        @(posedge clk); #1;
        rd(4, 32'h00000004, "R8 one edge not yet visible");
        rd(4, 32'hFFFFFFE6, "R8 two edges visible");

        // R9 interrupt remux sequence on pin 1
        wr(0, 32'h00000060, 32'h000000F0);
        rd(4, 32'hFFFFFFE4, "R9 irq reads stored");
        port(5, 128'h2, "R9 irq routed");
        wr(0, 32'h0, 32'h000000F0);
        rd(4, 32'hFFFFFFE6, "R9 remuxed reads level");
        wr(0, 32'h00000060, 32'h000000F0);
        rd(4, 32'hFFFFFFE4, "R9 restored reads stored");
        port(5, 128'h2, "R9 irq restored");

        // R10 unmapped offsets and banks
        wr(9, 32'hFFFFFFFF, 32'hFFFFFFFF);
        wr(32, 32'hFFFFFFFF, 32'hFFFFFFFF);
        rd(9, 32'h0, "R10 offset 9");
        rd(32, 32'h0, "R10 bank 2");
        rd(12, 32'h0, "R10 offset 12");
        port(1, (128'h1 << 63) | 128'h1, "R10 oe untouched");
        port(2, 128'h4, "R10 out untouched");
        port(3, 128'h1, "R10 pu untouched");

        // R11 bank 1 data word
        rd(20, 32'h7FFFFFFF, "R11 bank1 data");
        wr(20, 32'h80000000, 32'h80000000);
        port(2, (128'h1 << 63) | 128'h4, "R11 pin 63 out");
        rd(20, 32'hFFFFFFFF, "R11 bank1 stored bit");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule